// File: doc/BRIEF.md
# DV Isochronous Packet Assembler

This block turns a stream of compressed-video payload quadlets into complete isochronous packets for a serial-bus link transmitter. A command picks either a full data packet or an empty packet. A full data packet is 120 payload quadlets (480 bytes) behind a three-quadlet prefix. An empty packet is the prefix alone. The prefix is one isochronous header quadlet followed by two common-isochronous-packet (CIP) quadlets taken from configuration inputs.

Two optional features change the packet contents. The first is header-block insertion. When it is enabled, the block counts full packets from each frame marker. On every 25th full packet, starting with the first one after the marker, the first two payload quadlets are replaced by two programmable quadlets. The remaining bytes of the 80-byte header block pass through from the application. The second is timestamping. When it is enabled, the low 16 bits (the SYT field) of the second CIP quadlet are replaced by a timestamp input. A mode bit selects which packet carries the timestamp: either the first packet of any kind after a cycle marker, or the first full packet after a frame marker.

Top module: `dv_pkt_assembler`

## Requirements
- R1: The first quadlet of each packet is flagged with `out_sop`. Its layout is: bits 31:16 data length, bits 15:14 tag, bits 13:8 channel, bits 7:4 the constant 0xA, bits 3:0 sy.
- R2: A full packet is 123 quadlets with data length 488. `out_eop` is set on its last quadlet, and it takes exactly 120 payload quadlets.
- R3: An empty packet is 3 quadlets with data length 8. `out_eop` is set on the third quadlet, and it takes no payload quadlets.
- R4: Quadlet 1 equals `cfg_cip0`. Quadlet 2 equals `cfg_cip1` unless a timestamp is inserted.
- R5: With `cfg_h0_en` = 1, the first full packet after a frame marker, and every 25th full packet after that, emits `cfg_h0_q0` and `cfg_h0_q1` in place of payload quadlets 0 and 1. The replaced payload quadlets are still consumed, and payload quadlets 2 to 119 pass through unchanged.
- R6: The 25-packet count advances only on full packets, ignores empty packets, and restarts at every `frame_mark`.
- R7: With `cfg_h0_en` = 0, all 120 payload quadlets pass through unchanged, including those of a packet that would otherwise carry the header block.
- R8: With `cfg_ts_en` = 1 and `cfg_ts_mode` = 0, the first packet started after a `cycle_mark` pulse, full or empty, carries `{cfg_cip1[31:16], ts_value}` as quadlet 2. The packets after it do not.
- R9: With `cfg_ts_en` = 1 and `cfg_ts_mode` = 1, empty packets after a `frame_mark` pulse are not stamped. The first full packet after the pulse is stamped, and the packets after it are not.
- R10: With `cfg_ts_en` = 0, quadlet 2 equals `cfg_cip1` even right after a marker.
- R11: While `out_valid` is high and `out_ready` is low, the output quadlet holds. `pl_ready` is high only during the payload phase of a full packet while `out_ready` is high.
- R12: After reset, `out_valid` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Request to send one packet |
| cmd_full | input | 1 | 1 = full data packet, 0 = empty packet |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| pl_data | input | 32 | Payload quadlet |
| pl_valid | input | 1 | Payload quadlet valid |
| pl_ready | output | 1 | Payload quadlet taken |
| cfg_tag | input | 2 | Header tag field |
| cfg_channel | input | 6 | Header channel field |
| cfg_sy | input | 4 | Header sy field |
| cfg_cip0 | input | 32 | First CIP quadlet |
| cfg_cip1 | input | 32 | Second CIP quadlet |
| cfg_h0_en | input | 1 | Header-block insertion enable |
| cfg_h0_q0 | input | 32 | Header block bytes 0-3 |
| cfg_h0_q1 | input | 32 | Header block bytes 4-7 |
| cfg_ts_en | input | 1 | Timestamp insertion enable |
| cfg_ts_mode | input | 1 | 0 = after cycle marker, 1 = first full packet after frame marker |
| ts_value | input | 16 | Timestamp for the SYT field |
| cycle_mark | input | 1 | Isochronous cycle start pulse |
| frame_mark | input | 1 | Frame start pulse |
| out_data | output | 32 | Packet quadlet |
| out_valid | output | 1 | Packet quadlet valid |
| out_ready | input | 1 | Downstream accepts the quadlet |
| out_sop | output | 1 | First quadlet of a packet |
| out_eop | output | 1 | Last quadlet of a packet |

## Verification
Several properties are checked on every cycle:
- prefix quadlets hold while stalled,
- empty packets never draw payload,
- every start quadlet carries the 0xA tcode and one of the two legal lengths,
- the 25-packet counter stays in range,
- a timestamp claim clears the pending flag.

Only the bench scenarios show the rest. These are which packet receives the header block across a 25-packet run with interleaved empty packets, which packet takes the timestamp in each mode, and that payload quadlets arrive in order under back-pressure.

// File: rtl/dv_pkt_pkg.sv
package dv_pkt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} st_e;

  function automatic logic [31:0] iso_hdr(input logic [15:0] len, input logic [1:0] tag,
                                          input logic [5:0] ch, input logic [3:0] tcode,
                                          input logic [3:0] sy);
    return {len, tag, ch, tcode, sy};
  endfunction

  function automatic logic [31:0] put_syt(input logic [31:0] cip, input logic [15:0] ts);
    return {cip[31:16], ts};
  endfunction
endpackage

// File: rtl/dv_h0_sched.sv
module dv_h0_sched #(
  parameter int PERIOD = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_mark,
  input  logic start_full,
  output logic is_h0
);
  localparam int CW = $clog2(PERIOD);
  logic [CW-1:0] cnt;

  assign is_h0 = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (frame_mark) cnt <= '0;
    else if (start_full) cnt <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
  end

  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PERIOD));
  a_r6_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |=> is_h0);
endmodule

// File: rtl/dv_ts_arm.sv
module dv_ts_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic cycle_mark,
  input  logic frame_mark,
  input  logic pkt_start,
  input  logic pkt_full,
  output logic take
);
  logic armed, marker, eligible;

  assign marker   = mode ? frame_mark : cycle_mark;
  assign eligible = mode ? pkt_full : 1'b1;
  assign take     = armed & pkt_start & eligible;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else armed <= marker | (armed & ~take);
  end

  a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !marker) |=> !armed);
endmodule

// File: rtl/dv_pkt_assembler.sv
module dv_pkt_assembler
  import dv_pkt_pkg::*;
#(
  parameter int PAY_BYTES = 480,
  parameter int CIP_BYTES = 8,
  parameter int H0_PERIOD = 25,
  parameter int H0_QUADS  = 2,
  parameter logic [3:0] TCODE = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_full,
  output logic        cmd_ready,
  input  logic [31:0] pl_data,
  input  logic        pl_valid,
  output logic        pl_ready,
  input  logic [1:0]  cfg_tag,
  input  logic [5:0]  cfg_channel,
  input  logic [3:0]  cfg_sy,
  input  logic [31:0] cfg_cip0,
  input  logic [31:0] cfg_cip1,
  input  logic        cfg_h0_en,
  input  logic [31:0] cfg_h0_q0,
  input  logic [31:0] cfg_h0_q1,
  input  logic        cfg_ts_en,
  input  logic        cfg_ts_mode,
  input  logic [15:0] ts_value,
  input  logic        cycle_mark,
  input  logic        frame_mark,
  output logic [31:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_sop,
  output logic        out_eop
);
  localparam int PAY_Q     = PAY_BYTES / 4;
  localparam int HDR_Q     = 1 + CIP_BYTES / 4;
  localparam int FULL_LEN  = PAY_BYTES + CIP_BYTES;
  localparam int EMPTY_LEN = CIP_BYTES;
  localparam int WC_W      = $clog2(PAY_Q + 1);

  st_e state;
  logic [WC_W-1:0] wcnt;
  logic full_q, h0_q, stamp_q;
  logic [15:0] ts_q;

  // named internal events
  logic pkt_start, hdr_phase, pay_phase, fire, last_word, is_h0, ts_take;

  assign pkt_start = cmd_valid && (state == ST_IDLE);
  assign hdr_phase = (state == ST_HDR);
  assign pay_phase = (state == ST_PAY);
  assign fire      = out_valid && out_ready;
  assign last_word = out_eop;

  dv_h0_sched #(.PERIOD(H0_PERIOD)) u_h0 (
    .clk(clk), .rst_n(rst_n), .frame_mark(frame_mark),
    .start_full(pkt_start && cmd_full), .is_h0(is_h0));

  dv_ts_arm u_ts (
    .clk(clk), .rst_n(rst_n), .mode(cfg_ts_mode), .cycle_mark(cycle_mark),
    .frame_mark(frame_mark), .pkt_start(pkt_start), .pkt_full(cmd_full),
    .take(ts_take));

  assign cmd_ready = (state == ST_IDLE);
  assign pl_ready  = pay_phase && out_ready;

  always_comb begin
    out_data  = '0;
    out_valid = 1'b0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    if (hdr_phase) begin
      out_valid = 1'b1;
      out_sop   = (wcnt == '0);
      out_eop   = !full_q && (wcnt == WC_W'(HDR_Q - 1));
      case (wcnt)
        WC_W'(0): out_data = iso_hdr(full_q ? 16'(FULL_LEN) : 16'(EMPTY_LEN),
                                     cfg_tag, cfg_channel, TCODE, cfg_sy);
        WC_W'(1): out_data = cfg_cip0;
        default:  out_data = stamp_q ? put_syt(cfg_cip1, ts_q) : cfg_cip1;
      endcase
    end else if (pay_phase) begin
      out_valid = pl_valid;
      out_eop   = (wcnt == WC_W'(PAY_Q - 1));
      if (h0_q && wcnt < WC_W'(H0_QUADS))
        out_data = (wcnt == '0) ? cfg_h0_q0 : cfg_h0_q1;
      else
        out_data = pl_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      full_q  <= 1'b0;
      h0_q    <= 1'b0;
      stamp_q <= 1'b0;
      ts_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (pkt_start) begin
          state   <= ST_HDR;
          wcnt    <= '0;
          full_q  <= cmd_full;
          h0_q    <= cfg_h0_en && cmd_full && is_h0;
          stamp_q <= cfg_ts_en && ts_take;
          ts_q    <= ts_value;
        end
        ST_HDR: if (fire) begin
          if (wcnt == WC_W'(HDR_Q - 1)) begin
            wcnt  <= '0;
            state <= full_q ? ST_PAY : ST_IDLE;
          end else wcnt <= wcnt + 1'b1;
        end
        ST_PAY: if (fire) begin
          if (last_word) begin
            wcnt  <= '0;
            state <= ST_IDLE;
          end else wcnt <= wcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r11_hold_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_phase && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r3_empty_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !full_q) |-> !pl_ready);
  a_r1_start_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (out_data[7:4] == TCODE &&
      (out_data[31:16] == 16'(FULL_LEN) || out_data[31:16] == 16'(EMPTY_LEN))));
  a_r12_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);
endmodule

// File: tb/dv_pkt_assembler_bench.sv
module dv_pkt_assembler_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_full = 0, cmd_ready;
  logic [31:0] pl_data;
  logic pl_valid = 1, pl_ready;
  logic [1:0] cfg_tag = 2'd1;
  logic [5:0] cfg_channel = 6'd37;
  logic [3:0] cfg_sy = 4'h5;
  logic [31:0] cfg_cip0 = 32'h0078_0000, cfg_cip1 = 32'h8000_FFFF;
  logic cfg_h0_en = 0, cfg_ts_en = 0, cfg_ts_mode = 0;
  logic [31:0] cfg_h0_q0 = 32'h1F07_0000, cfg_h0_q1 = 32'h3F78_7878;
  logic [15:0] ts_value = 16'hBEEF;
  logic cycle_mark = 0, frame_mark = 0;
  logic [31:0] out_data;
  logic out_valid, out_ready = 1, out_sop, out_eop;

  int checks = 0, fails = 0, pl_idx = 0, got_n = 0, pl_taken = 0;
  logic [31:0] got [0:127];
  logic sop_ok;
  bit done_flag = 0;

  assign pl_data = 32'hD000_0000 | 32'(pl_idx);

  dv_pkt_assembler u_dv_pkt_assembler (
    .clk, .rst_n, .cmd_valid, .cmd_full, .cmd_ready, .pl_data, .pl_valid, .pl_ready,
    .cfg_tag, .cfg_channel, .cfg_sy, .cfg_cip0, .cfg_cip1, .cfg_h0_en, .cfg_h0_q0,
    .cfg_h0_q1, .cfg_ts_en, .cfg_ts_mode, .ts_value, .cycle_mark, .frame_mark,
    .out_data, .out_valid, .out_ready, .out_sop, .out_eop);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic pulse_cycle();
    @(negedge clk); cycle_mark = 1;
    @(negedge clk); cycle_mark = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_mark = 1;
    @(negedge clk); frame_mark = 0;
  endtask

  // issue one command and collect the packet; bp adds back-pressure
  task automatic run_pkt(input bit full, input bit bp);
    logic [31:0] held;
    bit held_v = 0, hold_ok = 1, done = 0;
    int cyc = 0;
    @(negedge clk); cmd_valid = 1; cmd_full = full;
    @(posedge clk); #1 cmd_valid = 0;
    got_n = 0; pl_taken = 0; sop_ok = 1;
    while (!done && cyc < 400) begin
      bit plf;
      @(negedge clk);
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (held_v && out_valid && out_data !== held) hold_ok = 0;
      held_v = out_valid && !out_ready;
      held = out_data;
      plf = pl_valid && pl_ready;
      if (out_valid && out_ready) begin
        if (out_sop != (got_n == 0)) sop_ok = 0;
        got[got_n] = out_data;
        got_n++;
        if (plf) pl_taken++;
        done = out_eop;
      end
      @(posedge clk); #1;
      if (plf) pl_idx++;
      cyc++;
    end
    out_ready = 1;
    if (bp) chk(hold_ok, "R11 stall hold", 0, 0);
  endtask

  function automatic logic [31:0] hdr_exp(input bit full);
    return {full ? 16'd488 : 16'd8, cfg_tag, cfg_channel, 4'hA, cfg_sy};
  endfunction

  // check a packet just collected
  task automatic check_pkt(input bit full, input bit exp_h0, input bit exp_ts,
                           input string tag, input int base);
    logic [31:0] w2;
    int bad = 0;
    w2 = exp_ts ? {cfg_cip1[31:16], ts_value} : cfg_cip1;
    chk(got_n == (full ? 123 : 3), full ? "R2 length" : "R3 length", got_n, full ? 123 : 3);
    chk(got[0] == hdr_exp(full) && sop_ok, {"R1 header ", tag}, got[0], hdr_exp(full));
    chk(got[1] == cfg_cip0, "R4 cip0", got[1], cfg_cip0);
    chk(got[2] == w2, {"R4 R8 R9 R10 cip1 ", tag}, got[2], w2);
    chk(pl_taken == (full ? 120 : 0), "R2 R3 payload taken", pl_taken, full ? 120 : 0);
    if (full && got_n == 123) begin
      for (int k = 0; k < 120; k++) begin
        logic [31:0] e;
        e = 32'hD000_0000 | 32'(base + k);
        if (exp_h0 && k == 0) e = cfg_h0_q0;
        if (exp_h0 && k == 1) e = cfg_h0_q1;
        if (got[3 + k] !== e) bad++;
      end
      chk(bad == 0, {"R5 R7 payload ", tag}, bad, 0);
    end
  endtask

  task automatic pkt(input bit full, input bit exp_h0, input bit exp_ts, input string tag,
                     input bit bp = 0);
    int base;
    base = pl_idx;
    run_pkt(full, bp);
    check_pkt(full, exp_h0, exp_ts, tag, base);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 0, "R12 out_valid", out_valid, 0);
    chk(cmd_ready == 1, "R12 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_plain();
    pkt(0, 0, 0, "empty");
    pkt(1, 0, 0, "full", 1);
    pkt(1, 0, 0, "full2");
    cfg_ts_en = 0; cfg_ts_mode = 0;
    pulse_cycle();
    pkt(0, 0, 0, "R10 ts off");
  endtask

  task automatic t_h0_off();
    cfg_h0_en = 0;
    pulse_frame();
    pkt(1, 0, 0, "R7 off at slot");
  endtask

  task automatic t_h0();
    cfg_h0_en = 1;
    pulse_frame();
    pkt(1, 1, 0, "R5 first");
    pkt(0, 0, 0, "R6 empty");
    for (int i = 1; i < 25; i++) begin
      if (i == 10) pkt(0, 0, 0, "R6 empty mid");
      pkt(1, 0, 0, "R6 mid");
    end
    pkt(1, 1, 0, "R5 25th");
    pkt(1, 0, 0, "R5 26th");
    pulse_frame();
    pkt(1, 1, 0, "R6 restart");
    cfg_h0_en = 0;
  endtask

  task automatic t_ts0();
    cfg_ts_en = 1; cfg_ts_mode = 0; ts_value = 16'h1234;
    pulse_cycle();
    pkt(0, 0, 1, "R8 empty stamped");
    pkt(1, 0, 0, "R8 next clear");
    pulse_cycle();
    pkt(1, 0, 1, "R8 full stamped");
  endtask

  task automatic t_ts1();
    cfg_ts_mode = 1; ts_value = 16'hBEEF;
    pulse_frame();
    pkt(0, 0, 0, "R9 empty skip");
    pkt(1, 0, 1, "R9 full stamped");
    pkt(1, 0, 0, "R9 after clear");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_h0_off();
    t_h0();
    t_ts0();
    t_ts1();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule